// File: doc/BRIEF.md
# Serial Interrogation Frame Validator

This block takes in an interrogation word one bit per receive clock, from a line modem that supplies a data bit, a frame-start sync marker and a validity flag. A frame is 32 bits long. Bit 0 arrives with the sync marker, and the block samples each bit on the rising clock edge. When a frame is complete, the block checks three things: the frame length, the odd parity over the whole word, and the modem validity flag for every bit of the frame. It then publishes four broadcast pulse bits together with a single validity flag.

A format-select input decides how word bit 6 is used. In the standard format, bit 6 is the fourth broadcast pulse bit. In the extended format, bit 6 goes to a separate terminal-address output and the fourth pulse bit reads 0. If any check fails, the frame is rejected: the validity flag drops and every field output reads 0. All outputs hold their values until the next frame result.

Top module: `intg_frame_validator`

## Requirements
- R1: After a synchronous active-low reset, `bcast_pulse`, `bcast_valid` and `term_addr0` are all 0.
- R2: A frame is 32 bits, numbered 0 to 31 in arrival order. `rx_sync` high marks bit 0, and the block samples `rx_data` on each rising edge of `rx_clk`. For an accepted frame, `bcast_valid` is 1 and `bcast_pulse[0]`, `bcast_pulse[1]`, `bcast_pulse[2]` equal word bits 3, 4, 5.
- R3: The outputs change on the rising edge that follows the edge sampling bit 31. Before that edge they still show the previous result. After it they hold until the next result.
- R4: When `ext_format` is 0, `bcast_pulse[3]` equals word bit 6 and `term_addr0` is 0.
- R5: When `ext_format` is 1, `term_addr0` equals word bit 6 and `bcast_pulse[3]` is 0. The block uses the `ext_format` value present on the edge that samples bit 31.
- R6: Bit 31 is a parity bit. The XOR of all 32 bits must be 1 (odd parity). A frame with even parity is rejected.
- R7: If `rx_valid` is low on the sampling edge of any bit of the frame, including bit 0 and bit 31, the frame is rejected.
- R8: If `rx_sync` goes high before bit 31 of the current frame, the cut-short frame is reported as rejected. The outputs take that result one edge after the sync edge. The sync bit becomes bit 0 of a new frame, and that new frame is then processed normally.
- R9: A rejected frame drives `bcast_valid`, all four `bcast_pulse` bits and `term_addr0` to 0.
- R10: Between frames, with `rx_sync` low, changes on `rx_data`, `rx_valid` and `ext_format` leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive bit clock; all sampling is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sync | input | 1 | High on the cycle carrying bit 0 of a frame |
| rx_data | input | 1 | Serial word data, bit 0 first |
| rx_valid | input | 1 | Modem validity flag for the bit on `rx_data` |
| ext_format | input | 1 | 0: bit 6 is pulse bit 4; 1: bit 6 is terminal address bit 0 |
| bcast_pulse | output | 4 | Broadcast pulse bits 1 to 4 (index 0 to 3) |
| bcast_valid | output | 1 | 1 when the last reported frame passed every check |
| term_addr0 | output | 1 | Terminal address bit 0 in extended format, else 0 |

## Verification
The embedded assertions check these properties on every cycle:
- the bit index never sits at zero inside a frame;
- a frame always closes after bit 31;
- a result appears only after the block was in a frame;
- a modem drop is always remembered or reported as a rejection;
- the outputs stay still between results;
- a rejected result carries all-zero fields;
- the address bit and the fourth pulse bit are never high together.

Only the bench scenarios can show the rest:
- that the correct word bits reach the correct outputs under each format setting;
- that parity, modem-drop and truncation errors each lead to a rejection at the correct edge;
- that the frame following a truncation is accepted with its own content.

// File: rtl/ifv_pkg.sv
// Package: shared constants and the result record of the interrogation
// frame validator. Assumes a fixed set of four broadcast pulse bits.
package ifv_pkg;
    localparam int unsigned PULSE_N = 4;

    typedef struct packed {
        logic [PULSE_N-1:0] pulse;
        logic               addr;
        logic               ok;
    } ifv_result_t;
endpackage

// File: rtl/ifv_frame_track.sv
// Frame tracker: keeps the index of the next expected bit and whether a
// frame is open. Flags the first bit, the last bit and a sync that cuts a
// frame short. Assumes one bit per clock and FRAME_LEN of at least 2.
module ifv_frame_track #(
    parameter int unsigned FRAME_LEN = 32,
    localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic [CNT_W-1:0] idx_o,
    output logic             in_frame_o,
    output logic             first_o,
    output logic             last_o,
    output logic             cut_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] idx_q;
    logic             open_q;

    // Decode the bit role of the current cycle from the sync and the count.
    always_comb begin
        first_o = sync_i;
        cut_o   = sync_i && open_q;
        last_o  = open_q && !sync_i && (idx_q == LAST_IDX);
    end

    // Advance the bit index; a sync always restarts the count at bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            open_q <= 1'b0;
        end else if (sync_i) begin
            idx_q  <= CNT_W'(1);
            open_q <= 1'b1;
        end else if (open_q) begin
            if (idx_q == LAST_IDX) begin
                idx_q  <= '0;
                open_q <= 1'b0;
            end else begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    assign idx_o      = idx_q;
    assign in_frame_o = open_q;

    assert_idx_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (idx_q != '0));
    assert_frame_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !open_q);
endmodule

// File: rtl/ifv_capture.sv
// Capture stage: stores each frame bit at its index and accumulates
// parity and modem errors. Emits a one-cycle done pulse with the reject
// verdict and the format setting. Assumes control strobes from the tracker.
module ifv_capture #(
    parameter int unsigned FRAME_LEN = 32,
    localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_i,
    input  logic                 rx_ok_i,
    input  logic                 fmt_i,
    input  logic                 first_i,
    input  logic                 in_frame_i,
    input  logic                 last_i,
    input  logic                 cut_i,
    input  logic [CNT_W-1:0]     idx_i,
    output logic [FRAME_LEN-1:0] word_o,
    output logic                 done_o,
    output logic                 reject_o,
    output logic                 fmt_o
);
    logic [FRAME_LEN-1:0] word_q;
    logic                 par_q;
    logic                 bad_q;
    logic                 done_q;
    logic                 rej_q;
    logic                 fmt_q;

    // Shift in bits, fold parity and modem status, close out on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            par_q  <= 1'b0;
            bad_q  <= 1'b0;
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            fmt_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (first_i) begin
                if (cut_i) begin
                    done_q <= 1'b1;
                    rej_q  <= 1'b1;
                end
                word_q[0] <= data_i;
                par_q     <= data_i;
                bad_q     <= !rx_ok_i;
            end else if (in_frame_i) begin
                word_q[idx_i] <= data_i;
                par_q         <= par_q ^ data_i;
                bad_q         <= bad_q | !rx_ok_i;
                if (last_i) begin
                    done_q <= 1'b1;
                    rej_q  <= bad_q | !rx_ok_i | !(par_q ^ data_i);
                    fmt_q  <= fmt_i;
                end
            end
        end
    end

    assign word_o   = word_q;
    assign done_o   = done_q;
    assign reject_o = rej_q;
    assign fmt_o    = fmt_q;

    assert_done_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(in_frame_i));
    assert_modem_drop_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_i && !first_i && !rx_ok_i) |=> (bad_q || (done_q && rej_q)));
    assert_cut_rejects_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cut_i |=> (done_q && rej_q));
endmodule

// File: rtl/ifv_field_out.sv
// Output stage: on a done pulse, loads the broadcast pulse bits, the
// address bit and the valid flag from the captured word, or zeros them on
// a reject. Holds them otherwise. Assumes the word is stable when done is high.
module ifv_field_out
    import ifv_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 32,
    parameter int unsigned PULSE_LSB = 3,
    parameter int unsigned SEL_POS   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic                 reject_i,
    input  logic                 fmt_i,
    input  logic [FRAME_LEN-1:0] word_i,
    output logic [PULSE_N-1:0]   pulse_o,
    output logic                 addr_o,
    output logic                 valid_o
);
    localparam int unsigned FIXED_N = PULSE_N - 1;

    ifv_result_t          nxt;
    ifv_result_t          res_q;
    logic [FIXED_N-1:0]   fixed_bits;

    // Pick the fixed-position pulse bits from consecutive word bits.
    for (genvar g = 0; g < FIXED_N; g++) begin : g_fixed
        assign fixed_bits[g] = word_i[PULSE_LSB + g];
    end

    // Build the next result, routing the shared bit according to the format.
    always_comb begin
        nxt = '0;
        if (!reject_i) begin
            nxt.pulse[FIXED_N-1:0] = fixed_bits;
            nxt.pulse[PULSE_N-1]   = fmt_i ? 1'b0 : word_i[SEL_POS];
            nxt.addr               = fmt_i ? word_i[SEL_POS] : 1'b0;
            nxt.ok                 = 1'b1;
        end
    end

    // Register the result on each done pulse and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (done_i) begin
            res_q <= nxt;
        end
    end

    assign pulse_o = res_q.pulse;
    assign addr_o  = res_q.addr;
    assign valid_o = res_q.ok;

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable({pulse_o, addr_o, valid_o}));
    assert_reject_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ((pulse_o == '0) && !addr_o));
    assert_addr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o |-> !pulse_o[PULSE_N-1]);
endmodule

// File: rtl/intg_frame_validator.sv
// Top level: serial interrogation frame validator. Chains the frame
// tracker, the capture stage and the output stage. Assumes the modem
// delivers one bit per rising edge of rx_clk, with sync on bit 0.
module intg_frame_validator
    import ifv_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 32,
    parameter int unsigned PULSE_LSB = 3,
    parameter int unsigned SEL_POS   = 6,
    localparam int unsigned CNT_W = $clog2(FRAME_LEN)
) (
    input  logic               rx_clk,
    input  logic               rst_n,
    input  logic               rx_sync,
    input  logic               rx_data,
    input  logic               rx_valid,
    input  logic               ext_format,
    output logic [PULSE_N-1:0] bcast_pulse,
    output logic               bcast_valid,
    output logic               term_addr0
);
    logic [CNT_W-1:0]     idx;
    logic                 in_frame;
    logic                 first_bit;
    logic                 last_bit;
    logic                 cut_short;
    logic [FRAME_LEN-1:0] word;
    logic                 done;
    logic                 reject;
    logic                 fmt;

    ifv_frame_track #(.FRAME_LEN(FRAME_LEN)) u_track (
        .clk        (rx_clk),
        .rst_n      (rst_n),
        .sync_i     (rx_sync),
        .idx_o      (idx),
        .in_frame_o (in_frame),
        .first_o    (first_bit),
        .last_o     (last_bit),
        .cut_o      (cut_short)
    );

    ifv_capture #(.FRAME_LEN(FRAME_LEN)) u_capture (
        .clk        (rx_clk),
        .rst_n      (rst_n),
        .data_i     (rx_data),
        .rx_ok_i    (rx_valid),
        .fmt_i      (ext_format),
        .first_i    (first_bit),
        .in_frame_i (in_frame),
        .last_i     (last_bit),
        .cut_i      (cut_short),
        .idx_i      (idx),
        .word_o     (word),
        .done_o     (done),
        .reject_o   (reject),
        .fmt_o      (fmt)
    );

    ifv_field_out #(
        .FRAME_LEN (FRAME_LEN),
        .PULSE_LSB (PULSE_LSB),
        .SEL_POS   (SEL_POS)
    ) u_out (
        .clk      (rx_clk),
        .rst_n    (rst_n),
        .done_i   (done),
        .reject_i (reject),
        .fmt_i    (fmt),
        .word_i   (word),
        .pulse_o  (bcast_pulse),
        .addr_o   (term_addr0),
        .valid_o  (bcast_valid)
    );
endmodule

// File: tb/tb_intg_frame_validator.sv
`timescale 1ns/1ps
module tb_intg_frame_validator;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_in, data_in, valid_in, fmt_in;
    logic [3:0] pulse;
    logic       pvalid, addr;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // Expected result held by the bench: {pulse[3:0], addr, valid}
    logic [5:0] exp_res = '0;

    always #2 clk = ~clk;

    intg_frame_validator dut (
        .rx_clk(clk), .rst_n(rst_n), .rx_sync(sync_in), .rx_data(data_in),
        .rx_valid(valid_in), .ext_format(fmt_in),
        .bcast_pulse(pulse), .bcast_valid(pvalid), .term_addr0(addr)
    );

    // Vector: [39:34] modem-drop bit index (63 = none), [33] force even parity,
    // [32] format, [30:0] payload bits 0..30 (bit 31 is computed parity)
    localparam int NV = 8;
    localparam logic [NV-1:0][39:0] VEC = {
        {6'd31, 1'b0, 1'b0, 32'h0000_0078},
        {6'd0,  1'b0, 1'b1, 32'h0000_0078},
        {6'd17, 1'b0, 1'b0, 32'h0000_0078},
        {6'd63, 1'b1, 1'b0, 32'h0000_0078},
        {6'd63, 1'b0, 1'b1, 32'h1234_5650},
        {6'd63, 1'b0, 1'b0, 32'h0000_0028},
        {6'd63, 1'b0, 1'b1, 32'h0000_0078},
        {6'd63, 1'b0, 1'b0, 32'h0000_0078}
    };

    function automatic logic [31:0] make_word(input logic [30:0] pl, input logic even);
        logic p;
        p = ^pl;
        // odd parity over 32 bits needs bit31 = ~p
        return {even ? p : ~p, pl};
    endfunction

    function automatic logic [5:0] expect_res(input logic [31:0] w, input logic f,
                                              input logic rej);
        if (rej) return 6'b0;
        return {(f ? 1'b0 : w[6]), w[5], w[4], w[3], (f ? w[6] : 1'b0), 1'b1};
    endfunction

    task automatic check(input string req, input logic [5:0] expv);
        checks++;
        if ({pulse, addr, pvalid} !== expv) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, {pulse, addr, pvalid}, expv);
        end
    endtask

    // Send a full frame; check hold before the result edge (R3) and the result.
    task automatic send_frame(input logic [31:0] w, input logic f, input int drop,
                              input logic cut_chk, input string req);
        logic [5:0] nx;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (cut_chk && i == 2) check("R8 cut-short frame rejected", 6'b0);
            sync_in  = (i == 0);
            data_in  = w[i];
            valid_in = (i != drop);
            fmt_in   = f;
        end
        @(negedge clk);
        sync_in = 0; valid_in = 1; fmt_in = ~f;
        if (cut_chk) exp_res = 6'b0;
        check("R3 previous result held before update", exp_res);
        nx = expect_res(w, f, (^w == 1'b0) || (drop >= 0 && drop < 32));
        @(negedge clk);
        check(req, nx);
        exp_res = nx;
    endtask

    initial begin
        rst_n = 0; sync_in = 0; data_in = 0; valid_in = 1; fmt_in = 0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 6'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1 state after reset release", 6'b0);

        // Table walk: R2 R4 R5 R6 R7 R9
        for (int v = NV - 1; v >= 0; v--) begin
            logic [39:0] e;
            int drop;
            e = VEC[v];
            drop = (e[39:34] == 6'd63) ? -1 : int'(e[39:34]);
            send_frame(make_word(e[30:0], e[33]), e[32], drop, 1'b0,
                       "R2 R4 R5 R6 R7 R9 table vector");
        end

        // Good frame so the outputs are non-zero (R2 R4)
        send_frame(make_word(31'h0000_0078, 1'b0), 1'b0, -1, 1'b0, "R4 standard format");

        // R10: idle noise with no sync leaves the outputs alone
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            data_in = i[0]; valid_in = i[1]; fmt_in = i[2];
        end
        @(negedge clk);
        check("R10 idle inputs ignored", exp_res);
        valid_in = 1;

        // R8: cut a frame short after 10 bits, then a full frame follows
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sync_in = (i == 0); data_in = 1'b1; valid_in = 1; fmt_in = 0;
        end
        send_frame(make_word(31'h0000_0050, 1'b0), 1'b1, -1, 1'b1,
                   "R8 frame after truncation accepted");

        // R5: extended format with bit6 clear
        send_frame(make_word(31'h0000_0038, 1'b0), 1'b1, -1, 1'b0, "R5 extended bit6 clear");

        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule